// File: doc/BRIEF.md
# Byte and word multiplier unit

This unit is the multiply engine of an 8/16-bit processor datapath. It takes a start strobe, a two-bit operation code, a 16-bit accumulator value and a 16-bit operand. It computes the product with a shift-add loop that handles one multiplier bit per clock. It then returns the product, the condition flags with a write enable for each flag, and a one-cycle completion pulse.

The unit has three operations. The byte operation multiplies the upper byte of the accumulator by its lower byte and returns a 16-bit product, leaving the flags alone. The signed word operation multiplies the accumulator by the operand as two's complement numbers and returns a 32-bit product. It finishes with one correction step for negative operands. The unsigned word operation returns the unsigned 32-bit product one clock later than the signed form. Both word operations write S, Z and C, and they clear P/V.

Top module: `bwmul_unit`

## Requirements
- R1: With op code 00 (byte), the 32-bit result is acc_i[15:8] * acc_i[7:0] (unsigned), and bits 31..16 of the result are zero.
- R2: A byte operation asserts none of the four flag write enables, and the flag outputs keep the values they had before it started.
- R3: With op code 10 (unsigned word), the result is the unsigned 32-bit product acc_i * opnd_i.
- R4: With op code 01 (signed word), the result is the 32-bit two's complement product of acc_i and opnd_i.
- R5: Counted in rising edges after the edge that samples start_i, done_o rises after 8 edges for byte, 17 for signed word and 18 for unsigned word. busy_o stays high from the edge after acceptance until the done cycle.
- R6: At the done of a word operation, all four write enables are high. S equals result bit 31, and Z is 1 exactly when all 32 result bits are 0.
- R7: At word done, C is 1 when result[31:16] is not the extension of result[15:0]: copies of bit 15 for signed, zero for unsigned.
- R8: At word done, P/V is 0.
- R9: A start pulse while busy_o is high is ignored: the running result, its latency and the count of done pulses are unchanged.
- R10: A start pulse with the reserved op code 11 is ignored: busy_o stays low and no done pulse follows.
- R11: While and right after reset, done_o, busy_o, all write enables, all flags and the result are zero.
- R12: done_o is high for exactly one cycle per accepted operation, and the write enables are high only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_i | input | 2 | 00 byte, 01 signed word, 10 unsigned word, 11 reserved |
| acc_i | input | 16 | Accumulator low half; in byte mode its two bytes are the factors |
| opnd_i | input | 16 | Word-mode operand |
| result_o | output | 32 | Product, held until the next completion |
| flag_s_o | output | 1 | Sign flag value |
| flag_z_o | output | 1 | Zero flag value |
| flag_c_o | output | 1 | Carry (overflow-of-half) flag value |
| flag_pv_o | output | 1 | Parity/overflow flag value |
| wen_s_o | output | 1 | Write enable for S |
| wen_z_o | output | 1 | Write enable for Z |
| wen_c_o | output | 1 | Write enable for C |
| wen_pv_o | output | 1 | Write enable for P/V |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | High while an operation is in flight |

## Verification
A corrupted multiplier shift register or a lost product addend shows up as a wrong result_o at the next done pulse, at most 18 cycles after start. A miscounted iteration counter shows up the same way, or as done_o arriving on the wrong edge. A bad correction term shows only for negative signed operands, so the vector table includes every sign pairing and both extremes of the 16-bit range. If the controller latches a new code while busy, the result or the write enables at that same done pulse come out wrong.

// File: rtl/bwmul_pkg.sv
package bwmul_pkg;

   // Operation codes presented on op_i.
   typedef enum logic [1:0] {
      OP_BYTE = 2'b00,
      OP_WSGN = 2'b01,
      OP_WUNS = 2'b10,
      OP_RSVD = 2'b11
   } mul_op_e;

   // Controller states.
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ITER = 2'b01,
      ST_FIX  = 2'b10,
      ST_HOLD = 2'b11
   } mul_st_e;

   typedef struct packed {
      logic s;
      logic z;
      logic c;
      logic pv;
   } mul_flags_t;

endpackage

// File: rtl/bwmul_ctrl.sv
module bwmul_ctrl
   import bwmul_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start_i,
   input  logic [1:0] op_i,
   output logic    load_o,
   output logic    step_o,
   output logic    fix_o,
   output logic    finish_o,
   output logic    busy_o,
   output mul_op_e op_o
);

   localparam int WORD_W = 2 * BYTE_W;
   localparam int CW     = $clog2(WORD_W + 1);

   mul_st_e        st_q, st_d;
   mul_op_e        op_q;
   logic [CW-1:0]  cnt_q;
   logic [CW-1:0]  limit;
   logic           last;
   logic           accept;

   assign accept = (st_q == ST_IDLE) && start_i && (op_i != OP_RSVD);
   assign limit  = (op_q == OP_BYTE) ? CW'(BYTE_W) : CW'(WORD_W);
   assign last   = (cnt_q == (limit - CW'(1)));

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (accept) st_d = ST_ITER;
         ST_ITER: begin
            if (last) st_d = (op_q == OP_BYTE) ? ST_IDLE : ST_FIX;
         end
         ST_FIX:  st_d = (op_q == OP_WSGN) ? ST_IDLE : ST_HOLD;
         ST_HOLD: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         op_q  <= OP_BYTE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            op_q  <= mul_op_e'(op_i);
            cnt_q <= '0;
         end else if (st_q == ST_ITER) begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign load_o   = accept;
   assign step_o   = (st_q == ST_ITER);
   assign fix_o    = (st_q == ST_FIX);
   assign finish_o = ((st_q == ST_ITER) && last && (op_q == OP_BYTE))
                   || ((st_q == ST_FIX) && (op_q == OP_WSGN))
                   || (st_q == ST_HOLD);
   assign busy_o   = (st_q != ST_IDLE);
   assign op_o     = op_q;

   // R9: the latched operation never changes while an operation runs.
   a_r9_op_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> (op_q == $past(op_q)));

   // R10: a reserved code leaves the controller idle.
   a_r10_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_IDLE) && start_i && (op_i == OP_RSVD)) |=> (st_q == ST_IDLE));

   // R5: the iteration counter stays inside the mode's bit count.
   a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ITER) |-> (cnt_q < limit));

endmodule

// File: rtl/bwmul_dpath.sv
module bwmul_dpath
   import bwmul_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic                  step_i,
   input  logic                  fix_i,
   input  logic [1:0]            op_new_i,
   input  mul_op_e               op_i,
   input  logic [2*BYTE_W-1:0]   acc_i,
   input  logic [2*BYTE_W-1:0]   opnd_i,
   output logic [4*BYTE_W-1:0]   prod_nxt_o
);

   localparam int WORD_W = 2 * BYTE_W;
   localparam int PROD_W = 2 * WORD_W;

   logic [WORD_W-1:0] a_q, b_q;
   logic [WORD_W-1:0] a_ld, b_ld;
   logic [PROD_W-1:0] mcand_q;
   logic [WORD_W-1:0] mplier_q;
   logic [PROD_W-1:0] prod_q;
   logic [PROD_W-1:0] addend;
   logic [PROD_W-1:0] corr;

   // Operand selection at load: byte mode splits the accumulator.
   always_comb begin
      if (mul_op_e'(op_new_i) == OP_BYTE) begin
         a_ld = {{BYTE_W{1'b0}}, acc_i[WORD_W-1:BYTE_W]};
         b_ld = {{BYTE_W{1'b0}}, acc_i[BYTE_W-1:0]};
      end else begin
         a_ld = acc_i;
         b_ld = opnd_i;
      end
   end

   assign addend = mplier_q[0] ? mcand_q : '0;

   // Signed correction: subtract each operand shifted up by the word
   // width when the other operand is negative (modulo 2^PROD_W).
   assign corr = (a_q[WORD_W-1] ? {b_q, {WORD_W{1'b0}}} : '0)
               + (b_q[WORD_W-1] ? {a_q, {WORD_W{1'b0}}} : '0);

   always_comb begin
      prod_nxt_o = prod_q;
      if (load_i) begin
         prod_nxt_o = '0;
      end else if (step_i) begin
         prod_nxt_o = prod_q + addend;
      end else if (fix_i && (op_i == OP_WSGN)) begin
         prod_nxt_o = prod_q - corr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q      <= '0;
         b_q      <= '0;
         mcand_q  <= '0;
         mplier_q <= '0;
         prod_q   <= '0;
      end else begin
         prod_q <= prod_nxt_o;
         if (load_i) begin
            a_q      <= a_ld;
            b_q      <= b_ld;
            mcand_q  <= {{WORD_W{1'b0}}, a_ld};
            mplier_q <= b_ld;
         end else if (step_i) begin
            mcand_q  <= {mcand_q[PROD_W-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[WORD_W-1:1]};
         end
      end
   end

   // R1: a byte-mode product never reaches the upper word.
   a_r1_byte_fits: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_BYTE) |-> (prod_q[PROD_W-1:WORD_W] == '0));

   // R3: during the loop the multiplier only loses bits.
   a_r3_mplier_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (mplier_q == ($past(mplier_q) >> 1)));

endmodule

// File: rtl/bwmul_flags.sv
module bwmul_flags
   import bwmul_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  mul_op_e              op_i,
   input  logic [4*BYTE_W-1:0]  prod_i,
   output mul_flags_t           flags_o
);

   localparam int WORD_W = 2 * BYTE_W;
   localparam int PROD_W = 2 * WORD_W;

   logic              ext_bit;
   logic [WORD_W-1:0] mism;

   assign ext_bit = (op_i == OP_WSGN) ? prod_i[WORD_W-1] : 1'b0;

   // One comparator per upper-half bit against the expected extension.
   for (genvar i = 0; i < WORD_W; i++) begin : g_ext
      assign mism[i] = prod_i[WORD_W + i] ^ ext_bit;
   end

   assign flags_o.s  = prod_i[PROD_W-1];
   assign flags_o.z  = ~|prod_i;
   assign flags_o.c  = |mism;
   assign flags_o.pv = 1'b0;

endmodule

// File: rtl/bwmul_unit.sv
module bwmul_unit
   import bwmul_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [1:0]           op_i,
   input  logic [2*BYTE_W-1:0]  acc_i,
   input  logic [2*BYTE_W-1:0]  opnd_i,
   output logic [4*BYTE_W-1:0]  result_o,
   output logic                 flag_s_o,
   output logic                 flag_z_o,
   output logic                 flag_c_o,
   output logic                 flag_pv_o,
   output logic                 wen_s_o,
   output logic                 wen_z_o,
   output logic                 wen_c_o,
   output logic                 wen_pv_o,
   output logic                 done_o,
   output logic                 busy_o
);

   localparam int PROD_W = 4 * BYTE_W;

   if (BYTE_W < 2) begin : g_bad_width
      $error("bwmul_unit: BYTE_W must be at least 2");
   end

   logic              load, step, fix, finish;
   mul_op_e           op_cur;
   logic [PROD_W-1:0] prod_nxt;
   mul_flags_t        flg_nxt;

   logic [PROD_W-1:0] res_q;
   mul_flags_t        flg_q;
   logic              wen_q;
   logic              done_q;

   bwmul_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (op_i),
      .load_o   (load),
      .step_o   (step),
      .fix_o    (fix),
      .finish_o (finish),
      .busy_o   (busy_o),
      .op_o     (op_cur)
   );

   bwmul_dpath #(.BYTE_W(BYTE_W)) u_dpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .step_i     (step),
      .fix_i      (fix),
      .op_new_i   (op_i),
      .op_i       (op_cur),
      .acc_i      (acc_i),
      .opnd_i     (opnd_i),
      .prod_nxt_o (prod_nxt)
   );

   bwmul_flags #(.BYTE_W(BYTE_W)) u_flags (
      .op_i    (op_cur),
      .prod_i  (prod_nxt),
      .flags_o (flg_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q  <= '0;
         flg_q  <= '0;
         wen_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         wen_q  <= finish && (op_cur != OP_BYTE);
         if (finish) begin
            res_q <= prod_nxt;
            if (op_cur != OP_BYTE) flg_q <= flg_nxt;
         end
      end
   end

   assign result_o  = res_q;
   assign flag_s_o  = flg_q.s;
   assign flag_z_o  = flg_q.z;
   assign flag_c_o  = flg_q.c;
   assign flag_pv_o = flg_q.pv;
   assign wen_s_o   = wen_q;
   assign wen_z_o   = wen_q;
   assign wen_c_o   = wen_q;
   assign wen_pv_o  = wen_q;
   assign done_o    = done_q;

   // R12: completion is a single-cycle pulse.
   a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R12: flag writes only accompany completion.
   a_r12_wen_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (wen_s_o || wen_z_o || wen_c_o || wen_pv_o) |-> done_o);

   // R2: a finished byte operation writes no flag.
   a_r2_byte_no_wen: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (op_cur == OP_BYTE)) |-> !(wen_s_o || wen_z_o || wen_c_o || wen_pv_o));

   // R8: P/V is cleared whenever it is written.
   a_r8_pv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wen_pv_o |-> !flag_pv_o);

   // R5: busy only drops in the cycle that completes.
   a_r5_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R6: S always mirrors the product's top bit after a word write.
   a_r6_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
      wen_s_o |-> (flag_s_o == result_o[PROD_W-1]));

endmodule

// File: tb/bwmul_unit_bench.sv
module bwmul_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 16;

   // Stimulus and expected latency per vector.
   localparam logic [1:0]  V_OP  [NV] = '{
      2'b00, 2'b00, 2'b00, 2'b00,
      2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
      2'b10, 2'b10, 2'b10, 2'b10, 2'b10 };
   localparam logic [15:0] V_ACC [NV] = '{
      16'hFFFF, 16'h0000, 16'h1234, 16'h8002,
      16'h0003, 16'hFFFF, 16'h8000, 16'h8000, 16'h7FFF, 16'h0000, 16'h0100,
      16'hFFFF, 16'h00FF, 16'h0000, 16'h8000, 16'h1234 };
   localparam logic [15:0] V_OPN [NV] = '{
      16'hAAAA, 16'h5555, 16'h0000, 16'hFFFF,
      16'h0004, 16'hFFFF, 16'h8000, 16'h0001, 16'hFFFF, 16'h1234, 16'hFF00,
      16'hFFFF, 16'h0101, 16'h9876, 16'h0002, 16'h5678 };
   localparam int          V_LAT [NV] = '{
      8, 8, 8, 8,
      17, 17, 17, 17, 17, 17, 17,
      18, 18, 18, 18, 18 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'b00;
   logic [15:0] acc_i = '0;
   logic [15:0] opnd_i = '0;
   logic [31:0] result_o;
   logic        flag_s_o, flag_z_o, flag_c_o, flag_pv_o;
   logic        wen_s_o, wen_z_o, wen_c_o, wen_pv_o;
   logic        done_o, busy_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bwmul_unit u_bwmul_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
      .flag_s_o(flag_s_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
      .flag_pv_o(flag_pv_o), .wen_s_o(wen_s_o), .wen_z_o(wen_z_o),
      .wen_c_o(wen_c_o), .wen_pv_o(wen_pv_o), .done_o(done_o), .busy_o(busy_o));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_prod(input logic [1:0] op,
                                            input logic [15:0] a,
                                            input logic [15:0] b);
      logic signed [31:0] sa, sb;
      if (op == 2'b00) return {16'h0, 8'h0, a[15:8]} * {16'h0, 8'h0, a[7:0]};
      if (op == 2'b10) return {16'h0, a} * {16'h0, b};
      sa = $signed({{16{a[15]}}, a});
      sb = $signed({{16{b[15]}}, b});
      return 32'(sa * sb);
   endfunction

   function automatic logic exp_c(input logic [1:0] op, input logic [31:0] p);
      if (op == 2'b01) return p[31:16] != {16{p[15]}};
      return p[31:16] != 16'h0;
   endfunction

   // Issue one operation and wait for done; returns edges counted.
   task automatic issue(input logic [1:0] op, input logic [15:0] a,
                        input logic [15:0] b, output int k);
      @(negedge clk);
      op_i = op; acc_i = a; opnd_i = b; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      k = 0;
      do begin
         @(posedge clk);
         k++;
         @(negedge clk);
      end while (!done_o && k < 100);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int k;
      logic [31:0] p;
      logic s0, z0, c0;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk(!done_o && !busy_o, "R11", "done/busy in reset", {30'h0, done_o, busy_o}, 32'h0);
      chk(result_o == 32'h0, "R11", "result in reset", result_o, 32'h0);
      chk({flag_s_o, flag_z_o, flag_c_o, flag_pv_o, wen_s_o, wen_z_o, wen_c_o, wen_pv_o} == 8'h0,
          "R11", "flags/wen in reset",
          {24'h0, flag_s_o, flag_z_o, flag_c_o, flag_pv_o, wen_s_o, wen_z_o, wen_c_o, wen_pv_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_o && !busy_o && result_o == 0, "R11", "after release",
          {30'h0, done_o, busy_o}, 32'h0);

      // Vector table: R1 R3 R4 R5 R6 R7 R8 R2
      for (int i = 0; i < NV; i++) begin
         issue(V_OP[i], V_ACC[i], V_OPN[i], k);
         p = exp_prod(V_OP[i], V_ACC[i], V_OPN[i]);
         chk(k == V_LAT[i], "R5", "latency", k, V_LAT[i]);
         if (V_OP[i] == 2'b00)      chk(result_o == p, "R1", "byte product", result_o, p);
         else if (V_OP[i] == 2'b01) chk(result_o == p, "R4", "signed product", result_o, p);
         else                       chk(result_o == p, "R3", "unsigned product", result_o, p);
         if (V_OP[i] == 2'b00) begin
            chk({wen_s_o, wen_z_o, wen_c_o, wen_pv_o} == 4'h0, "R2", "byte wen",
                {28'h0, wen_s_o, wen_z_o, wen_c_o, wen_pv_o}, 32'h0);
         end else begin
            chk({wen_s_o, wen_z_o, wen_c_o, wen_pv_o} == 4'hF, "R6", "word wen",
                {28'h0, wen_s_o, wen_z_o, wen_c_o, wen_pv_o}, 32'hF);
            chk(flag_s_o == p[31], "R6", "S flag", flag_s_o, p[31]);
            chk(flag_z_o == (p == 0), "R6", "Z flag", flag_z_o, p == 0);
            chk(flag_c_o == exp_c(V_OP[i], p), "R7", "C flag", flag_c_o, exp_c(V_OP[i], p));
            chk(flag_pv_o == 1'b0, "R8", "PV flag", flag_pv_o, 0);
         end
         @(negedge clk);
         chk(!done_o && !wen_s_o, "R12", "done single cycle", {31'h0, done_o}, 32'h0);
      end

      // R2: a byte operation leaves earlier flag values intact
      issue(2'b10, 16'hFFFF, 16'hFFFF, k);
      s0 = flag_s_o; z0 = flag_z_o; c0 = flag_c_o;
      issue(2'b00, 16'h0000, 16'h0000, k);
      chk({flag_s_o, flag_z_o, flag_c_o} == {s0, z0, c0}, "R2", "flags held over byte op",
          {29'h0, flag_s_o, flag_z_o, flag_c_o}, {29'h0, s0, z0, c0});

      // R9: start while busy is ignored
      @(negedge clk);
      op_i = 2'b00; acc_i = 16'h0C0D; opnd_i = 16'h0; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      k = 0;
      do begin
         @(posedge clk);
         k++;
         @(negedge clk);
         if (k == 3) begin
            op_i = 2'b10; acc_i = 16'hFFFF; opnd_i = 16'hFFFF; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
      end while (!done_o && k < 100);
      chk(k == 8, "R9", "latency with busy start", k, 8);
      chk(result_o == 32'd156, "R9", "result with busy start", result_o, 32'd156);
      k = 0;
      for (int j = 0; j < 30; j++) begin
         @(negedge clk);
         if (done_o) k++;
      end
      chk(k == 0, "R9", "no extra done", k, 0);

      // R10: reserved code ignored
      @(negedge clk);
      op_i = 2'b11; acc_i = 16'h1111; opnd_i = 16'h2222; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk(!busy_o, "R10", "busy after reserved start", busy_o, 0);
      k = 0;
      for (int j = 0; j < 30; j++) begin
         @(negedge clk);
         if (done_o || busy_o) k++;
      end
      chk(k == 0, "R10", "no activity after reserved start", k, 0);
      chk(result_o == 32'd156, "R10", "result unchanged", result_o, 32'd156);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule